// File: doc/BRIEF.md
# Multi-Mode Pixel Histogram Engine

A single 1024-word by 24-bit bin memory is shared by six synchronous pixel-processing functions. A 3-bit function code, latched on a rising edge of a load strobe, picks the function:

- counting pixel occurrences into bins
- summing bins into a running total
- adding weighted data to bins
- loading and reading a look-up table
- delaying a data stream by the full memory depth
- subtracting the live sample from the delayed one

Each operation is captured on a clock edge. It reads its word through a registered memory port, and its result reaches the output register on the second rising edge after capture. A write-through path from the write port to the read register keeps back-to-back updates of one bin exact. An active-low flash clear zeroes every memory word and every datapath register in one clock.

Top module: `pixhist_engine`

## Requirements
- R1: The function code is copied into the mode register only on a clock edge where the load strobe is high and was low at the previous edge. Codes: 000 count, 001 bin sum, 010 delay-subtract, 011 table, 100 weighted add, 101 delay, 110 and 111 host (idle). With no such edge, a change on the code input has no effect.
- R2: In count mode, each pixel captured with run_n low increments its bin by one. The new count is shown on the output after the second rising edge following capture. Consecutive hits on the same bin lose no count.
- R3: Bin updates in count and weighted-add modes saturate at 0xFFFFFF instead of wrapping.
- R4: In weighted-add mode, with run_n low, the data input is added to the pixel-addressed word. The sum is written back and output.
- R5: In table mode, with run_n low, rd_n high writes the data input to the pixel-addressed word, and rd_n low outputs that word.
- R6: In bin-sum mode, with run_n low, the addressed word is added to a saturating accumulator and the accumulator is output. Memory is not modified. The accumulator is zeroed whenever a function code is loaded.
- R7: In delay mode, every clock writes the data input at a circular pointer and outputs the word previously stored there, so the output repeats the input 1024 samples later. run_n is ignored.
- R8: In delay-subtract mode, the output is the delayed word minus the current data input, modulo 2^24. The data input is also stored. run_n is ignored.
- R9: In count, bin-sum, weighted-add and table modes, run_n high makes a cycle a no-op: memory and output hold.
- R10: flash_clr_n low zeroes every memory word, the output register, the accumulator, the delay pointer and the pipeline. It also selects count mode.
- R11: dout_en equals the inverse of rd_n. While rd_n is high, dout reads zero.
- R12: Function codes 110 and 111 perform no operation: memory and output hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| flash_clr_n | input | 1 | Synchronous active-low clear of memory and datapath |
| func_ld | input | 1 | Function load strobe, acts on its rising edge |
| func_code | input | 3 | Function code |
| run_n | input | 1 | Active-low operation enable for the gated modes |
| rd_n | input | 1 | Active-low output enable; table write select when high |
| pix_in | input | 10 | Pixel value, bin address |
| din | input | 24 | Data input |
| dout | output | 24 | Registered result, zero while disabled |
| dout_en | output | 1 | Output valid flag |

## Verification
The assertions check several rules on every clock: the output-enable gating, that the mode changes only after a load edge and then holds the loaded code, that clearing leaves the output register zero in count mode, and that the output stays frozen after three quiet cycles in a gated or host mode. The arithmetic can only be shown by the bench's scenarios against its reference model: forwarded same-bin counts, saturation at full scale, the weighted sums, the running bin sum, the 1024-sample delay and the modular subtraction. The same holds for a flash clear that wipes stored bins.

// File: rtl/pixhist_pkg.sv
package pixhist_pkg;

   typedef enum logic [2:0] {
      FN_COUNT  = 3'b000,
      FN_BINSUM = 3'b001,
      FN_DSUB   = 3'b010,
      FN_TABLE  = 3'b011,
      FN_WADD   = 3'b100,
      FN_DELAY  = 3'b101,
      FN_HOSTW  = 3'b110,
      FN_HOSTN  = 3'b111
   } fn_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_INC,
      OP_SUM,
      OP_ADD,
      OP_WR,
      OP_RD,
      OP_DLY,
      OP_DSUB
   } op_e;

endpackage

// File: rtl/pixhist_bram.sv
module pixhist_bram #(
   parameter int AW     = 10,
   parameter int DW     = 24,
   parameter bit BYPASS = 1'b1
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem_q [DEPTH];
   logic          fwd;

   // write-through variant: a read that collides with the write of the
   // same edge returns the new word
   generate
      if (BYPASS) begin : g_fwd
         assign fwd = we && (waddr == raddr);
      end else begin : g_nofwd
         assign fwd = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!clr_n) begin
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
         rdata <= '0;
      end else begin
         if (we) mem_q[waddr] <= wdata;
         rdata <= fwd ? wdata : mem_q[raddr];
      end
   end
endmodule

// File: rtl/pixhist_modectl.sv
module pixhist_modectl
   import pixhist_pkg::*;
#(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          clr_n,
   input  logic          func_ld,
   input  logic [2:0]    func_code,
   input  logic          run_n,
   input  logic          rd_n,
   input  logic [AW-1:0] pix_in,
   output fn_e           mode_q,
   output logic          mode_load,
   output op_e           op_a,
   output logic [AW-1:0] addr_a
);
   logic          ld_q;
   logic [AW-1:0] ptr_q;
   op_e           op_nxt;
   logic          use_ptr;

   assign mode_load = func_ld & ~ld_q;

   always_comb begin
      op_nxt  = OP_NONE;
      use_ptr = 1'b0;
      case (mode_q)
         FN_COUNT:  op_nxt = run_n ? OP_NONE : OP_INC;
         FN_BINSUM: op_nxt = run_n ? OP_NONE : OP_SUM;
         FN_WADD:   op_nxt = run_n ? OP_NONE : OP_ADD;
         FN_TABLE:  op_nxt = run_n ? OP_NONE : (rd_n ? OP_WR : OP_RD);
         FN_DELAY: begin
            op_nxt  = OP_DLY;
            use_ptr = 1'b1;
         end
         FN_DSUB: begin
            op_nxt  = OP_DSUB;
            use_ptr = 1'b1;
         end
         default:   op_nxt = OP_NONE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!clr_n) begin
         ld_q   <= 1'b0;
         mode_q <= FN_COUNT;
         op_a   <= OP_NONE;
         addr_a <= '0;
         ptr_q  <= '0;
      end else begin
         ld_q <= func_ld;
         if (mode_load) mode_q <= fn_e'(func_code);
         op_a   <= op_nxt;
         addr_a <= use_ptr ? ptr_q : pix_in;
         if (use_ptr) ptr_q <= ptr_q + 1'b1;
      end
   end
endmodule

// File: rtl/pixhist_alu.sv
module pixhist_alu
   import pixhist_pkg::*;
#(
   parameter int DW       = 24,
   parameter bit SATURATE = 1'b1
) (
   input  op_e           op,
   input  logic [DW-1:0] old_word,
   input  logic [DW-1:0] din_word,
   input  logic [DW-1:0] acc_word,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic          res_we,
   output logic [DW-1:0] res_val,
   output logic          acc_we,
   output logic [DW-1:0] acc_nxt
);
   logic [DW:0]   inc_raw, add_raw, acc_raw;
   logic [DW-1:0] inc_w, add_w, acc_w;

   assign inc_raw = {1'b0, old_word} + {{DW{1'b0}}, 1'b1};
   assign add_raw = {1'b0, old_word} + {1'b0, din_word};
   assign acc_raw = {1'b0, acc_word} + {1'b0, old_word};

   generate
      if (SATURATE) begin : g_sat
         assign inc_w = inc_raw[DW] ? '1 : inc_raw[DW-1:0];
         assign add_w = add_raw[DW] ? '1 : add_raw[DW-1:0];
         assign acc_w = acc_raw[DW] ? '1 : acc_raw[DW-1:0];
      end else begin : g_wrap
         assign inc_w = inc_raw[DW-1:0];
         assign add_w = add_raw[DW-1:0];
         assign acc_w = acc_raw[DW-1:0];
      end
   endgenerate

   always_comb begin
      mem_we    = 1'b0;
      mem_wdata = din_word;
      res_we    = 1'b0;
      res_val   = old_word;
      acc_we    = 1'b0;
      acc_nxt   = acc_w;
      case (op)
         OP_INC: begin
            mem_we    = 1'b1;
            mem_wdata = inc_w;
            res_we    = 1'b1;
            res_val   = inc_w;
         end
         OP_SUM: begin
            acc_we  = 1'b1;
            res_we  = 1'b1;
            res_val = acc_w;
         end
         OP_ADD: begin
            mem_we    = 1'b1;
            mem_wdata = add_w;
            res_we    = 1'b1;
            res_val   = add_w;
         end
         OP_WR:   mem_we = 1'b1;
         OP_RD:   res_we = 1'b1;
         OP_DLY: begin
            mem_we = 1'b1;
            res_we = 1'b1;
         end
         OP_DSUB: begin
            mem_we  = 1'b1;
            res_we  = 1'b1;
            res_val = old_word - din_word;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/pixhist_engine.sv
module pixhist_engine
   import pixhist_pkg::*;
#(
   parameter int AW       = 10,
   parameter int DW       = 24,
   parameter bit SATURATE = 1'b1,
   parameter bit BYPASS   = 1'b1
) (
   input  logic          clk,
   input  logic          flash_clr_n,
   input  logic          func_ld,
   input  logic [2:0]    func_code,
   input  logic          run_n,
   input  logic          rd_n,
   input  logic [AW-1:0] pix_in,
   input  logic [DW-1:0] din,
   output logic [DW-1:0] dout,
   output logic          dout_en
);
   generate
      if (AW < 2 || AW > 12) begin : g_bad_aw
         $error("pixhist_engine: AW must lie in 2..12");
      end
      if (DW < 4) begin : g_bad_dw
         $error("pixhist_engine: DW must be at least 4");
      end
   endgenerate

   fn_e           mode_q;
   logic          mode_load;
   op_e           op_a, op_b;
   logic [AW-1:0] addr_a, addr_b;
   logic [DW-1:0] din_a, din_b;
   logic [DW-1:0] rdata, acc_q, result_q;
   logic          mem_we, res_we, acc_we;
   logic [DW-1:0] mem_wdata, res_val, acc_nxt;

   pixhist_modectl #(.AW(AW)) u_ctl (
      .clk      (clk),
      .clr_n    (flash_clr_n),
      .func_ld  (func_ld),
      .func_code(func_code),
      .run_n    (run_n),
      .rd_n     (rd_n),
      .pix_in   (pix_in),
      .mode_q   (mode_q),
      .mode_load(mode_load),
      .op_a     (op_a),
      .addr_a   (addr_a)
   );

   pixhist_bram #(.AW(AW), .DW(DW), .BYPASS(BYPASS)) u_mem (
      .clk  (clk),
      .clr_n(flash_clr_n),
      .we   (mem_we),
      .waddr(addr_b),
      .wdata(mem_wdata),
      .raddr(addr_a),
      .rdata(rdata)
   );

   pixhist_alu #(.DW(DW), .SATURATE(SATURATE)) u_alu (
      .op       (op_b),
      .old_word (rdata),
      .din_word (din_b),
      .acc_word (acc_q),
      .mem_we   (mem_we),
      .mem_wdata(mem_wdata),
      .res_we   (res_we),
      .res_val  (res_val),
      .acc_we   (acc_we),
      .acc_nxt  (acc_nxt)
   );

   always_ff @(posedge clk) begin
      if (!flash_clr_n) begin
         din_a    <= '0;
         din_b    <= '0;
         op_b     <= OP_NONE;
         addr_b   <= '0;
         acc_q    <= '0;
         result_q <= '0;
      end else begin
         din_a  <= din;
         din_b  <= din_a;
         op_b   <= op_a;
         addr_b <= addr_a;
         if (mode_load)   acc_q <= '0;
         else if (acc_we) acc_q <= acc_nxt;
         if (res_we) result_q <= res_val;
      end
   end

   assign dout    = rd_n ? '0 : result_q;
   assign dout_en = ~rd_n;
endmodule

// File: rtl/pixhist_chk.sv
module pixhist_chk #(
   parameter int DW = 24
) (
   input logic          clk,
   input logic          flash_clr_n,
   input logic          func_ld,
   input logic [2:0]    func_code,
   input logic          run_n,
   input logic          rd_n,
   input logic [DW-1:0] dout,
   input logic          dout_en,
   input logic [2:0]    mode_q,
   input logic [DW-1:0] result_q
);
   logic       ld_prev;
   logic       quiet;
   logic [1:0] quiet_cnt;

   assign quiet = !func_ld &&
                  (((mode_q inside {3'b000, 3'b001, 3'b011, 3'b100}) && run_n) ||
                   (mode_q[2:1] == 2'b11));

   always_ff @(posedge clk) begin
      if (!flash_clr_n) begin
         ld_prev   <= 1'b0;
         quiet_cnt <= 2'd0;
      end else begin
         ld_prev   <= func_ld;
         quiet_cnt <= !quiet ? 2'd0 : ((quiet_cnt == 2'd3) ? 2'd3 : quiet_cnt + 2'd1);
      end
   end

   assert_oe_R11: assert property (@(posedge clk)
      (dout_en != rd_n) && (rd_n ? (dout == '0) : (dout == result_q)));

   assert_clear_R10: assert property (@(posedge clk)
      !flash_clr_n |=> (result_q == '0 && mode_q == 3'b000));

   assert_load_R1: assert property (@(posedge clk) disable iff (!flash_clr_n)
      (func_ld && !ld_prev) |=> (mode_q == $past(func_code)));

   assert_hold_R1: assert property (@(posedge clk) disable iff (!flash_clr_n)
      !(func_ld && !ld_prev) |=> $stable(mode_q));

   // covers R12 as well: host codes count as quiet cycles
   assert_quiet_R9: assert property (@(posedge clk) disable iff (!flash_clr_n)
      (quiet_cnt == 2'd3) |-> $stable(result_q));
endmodule

bind pixhist_engine pixhist_chk #(.DW(DW)) chk_i (
   .clk        (clk),
   .flash_clr_n(flash_clr_n),
   .func_ld    (func_ld),
   .func_code  (func_code),
   .run_n      (run_n),
   .rd_n       (rd_n),
   .dout       (dout),
   .dout_en    (dout_en),
   .mode_q     (mode_q),
   .result_q   (result_q)
);

// File: tb/pixhist_engine_tb_top.sv
module pixhist_engine_tb_top;
   logic        clk = 1'b0;
   logic        flash_clr_n, func_ld, run_n, rd_n;
   logic [2:0]  func_code;
   logic [9:0]  pix_in;
   logic [23:0] din, dout;
   logic        dout_en;

   always #5 clk = ~clk;

   pixhist_engine dut_i (
      .clk(clk), .flash_clr_n(flash_clr_n), .func_ld(func_ld), .func_code(func_code),
      .run_n(run_n), .rd_n(rd_n), .pix_in(pix_in), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   int    total = 0;
   int    bad = 0;
   string req = "R10";

   logic [23:0] mmem [1024];
   logic [23:0] mres, macc, p0val, p1val;
   logic        p0v, p1v, mldq;
   logic [2:0]  mmode;
   logic [9:0]  mptr;

   function automatic logic [23:0] sat24(input logic [24:0] s);
      return s[24] ? 24'hFFFFFF : s[23:0];
   endfunction

   task automatic model_step();
      logic [23:0] nv;
      if (!flash_clr_n) begin
         for (int i = 0; i < 1024; i++) mmem[i] = 24'h0;
         mres = 0; macc = 0; p0v = 0; p1v = 0; p0val = 0; p1val = 0;
         mmode = 3'b000; mptr = 0; mldq = 0;
         return;
      end
      if (p1v) mres = p1val;
      p1v = p0v; p1val = p0val; p0v = 0;
      case (mmode)
         3'b000: if (!run_n) begin
            nv = sat24({1'b0, mmem[pix_in]} + 25'd1);
            mmem[pix_in] = nv; p0v = 1; p0val = nv;
         end
         3'b001: if (!run_n) begin
            macc = sat24({1'b0, macc} + {1'b0, mmem[pix_in]});
            p0v = 1; p0val = macc;
         end
         3'b100: if (!run_n) begin
            nv = sat24({1'b0, mmem[pix_in]} + {1'b0, din});
            mmem[pix_in] = nv; p0v = 1; p0val = nv;
         end
         3'b011: if (!run_n) begin
            if (rd_n) mmem[pix_in] = din;
            else begin p0v = 1; p0val = mmem[pix_in]; end
         end
         3'b101: begin
            p0v = 1; p0val = mmem[mptr]; mmem[mptr] = din; mptr = mptr + 1'b1;
         end
         3'b010: begin
            p0v = 1; p0val = mmem[mptr] - din; mmem[mptr] = din; mptr = mptr + 1'b1;
         end
         default: ;
      endcase
      if (func_ld && !mldq) begin mmode = func_code; macc = 0; end
      mldq = func_ld;
   endtask

   task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1 model_step();
      @(negedge clk);
      check(req, dout, rd_n ? 24'h0 : mres);
      check("R11", {23'h0, dout_en}, {23'h0, ~rd_n});
   endtask

   task automatic load(input logic [2:0] f);
      run_n = 1; tick(); tick();
      func_code = f; func_ld = 1; tick();
      func_ld = 0; tick();
   endtask

   task automatic rand_ticks(input int n, input int pmod, input int dmask);
      for (int i = 0; i < n; i++) begin
         pix_in = 10'($urandom % pmod);
         din    = 24'($urandom) & 24'(dmask);
         run_n  = ($urandom % 4) == 0;
         rd_n   = ($urandom % 3) == 0;
         tick();
      end
      run_n = 1; rd_n = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7341));
      flash_clr_n = 0; func_ld = 0; func_code = 0; run_n = 1; rd_n = 0;
      pix_in = 0; din = 0;
      // R10: reset state
      tick(); tick(); tick();
      check("R10", dout, 24'h0);
      flash_clr_n = 1;

      // R2: back-to-back hits on one bin, then random counting
      req = "R2";
      pix_in = 10'd5; run_n = 0;
      repeat (4) tick();
      run_n = 1; tick(); tick();
      check("R2", dout, 24'd4);
      rand_ticks(300, 12, 0);

      // R1: code change without a load edge keeps count mode
      req = "R1";
      func_code = 3'b100; din = 24'h00ABCD; pix_in = 10'd5; run_n = 0;
      repeat (3) tick();
      run_n = 1; tick(); tick();

      // R9: run_n high leaves memory and output alone
      req = "R9";
      for (int i = 0; i < 6; i++) begin pix_in = 10'(i); tick(); end
      load(3'b011);
      run_n = 1; rd_n = 1; pix_in = 10'd5; din = 24'h123456; tick();
      rd_n = 0; run_n = 0; tick(); run_n = 1; tick(); tick();

      // R5: table loading and reading
      req = "R5";
      rand_ticks(250, 32, 24'hFFFFFF);

      // R3: saturation of a count near full scale
      req = "R3";
      run_n = 0; rd_n = 1; pix_in = 10'd7; din = 24'hFFFFFE; tick();
      run_n = 1; rd_n = 0;
      load(3'b000);
      pix_in = 10'd7; run_n = 0; repeat (3) tick();
      run_n = 1; tick(); tick();
      check("R3", dout, 24'hFFFFFF);

      // R4: weighted add, including a saturating sum
      req = "R4";
      load(3'b100);
      run_n = 0; pix_in = 10'd9; din = 24'hFFFFF0; tick();
      din = 24'h000020; tick();
      run_n = 1; tick(); tick();
      check("R4", dout, 24'hFFFFFF);
      rand_ticks(200, 16, 24'h00FFFF);

      // R6: running bin sum, accumulator zeroed by a load
      req = "R6";
      load(3'b001);
      for (int p = 0; p < 32; p++) begin pix_in = 10'(p); run_n = 0; tick(); end
      run_n = 1; tick(); tick();
      load(3'b001);
      for (int p = 0; p < 4; p++) begin pix_in = 10'(p); run_n = 0; tick(); end
      run_n = 1; tick(); tick();
      load(3'b011);
      for (int p = 0; p < 32; p++) begin pix_in = 10'(p); run_n = 0; tick(); end
      run_n = 1; tick(); tick();

      // R12: host codes do nothing
      req = "R12";
      load(3'b110);
      rand_ticks(50, 32, 24'hFFFFFF);
      load(3'b111);
      rand_ticks(50, 32, 24'hFFFFFF);
      load(3'b011);
      for (int p = 0; p < 16; p++) begin pix_in = 10'(p); run_n = 0; tick(); end
      run_n = 1; tick(); tick();

      // R7: full-depth delay line
      req = "R7";
      load(3'b101);
      rand_ticks(1100, 1024, 24'hFFFFFF);

      // R8: delay and subtract
      req = "R8";
      load(3'b010);
      rand_ticks(1100, 1024, 24'hFFFFFF);

      // R10: clear mid-run, then count mode with empty bins
      req = "R10";
      flash_clr_n = 0; tick();
      flash_clr_n = 1; rd_n = 0;
      pix_in = 10'd3; run_n = 0; tick();
      run_n = 1; tick(); tick();
      check("R10", dout, 24'd1);
      load(3'b011);
      for (int p = 0; p < 20; p++) begin pix_in = 10'($urandom % 1024); run_n = 0; tick(); end
      run_n = 1; tick(); tick();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule